// File: doc/BRIEF.md
# Grouped Carry-Lookahead Adder

A purely combinational adder for two unsigned operands and a carry-in. It returns the sum and the carry-out. Every bit position forms a propagate term (operand bits differ) and a generate term (both operand bits set). The bits are then gathered into 4-bit groups, and each group reduces its four bit terms to one group propagate and one group generate. A carry can therefore cross a whole group in one step instead of passing through its four bits one at a time. Inside a group, the carries into bits 1 to 3 come from a two-level lookahead over that group's bit terms and the group's carry-in.

The operand width is a parameter and must be a multiple of 4. Both 16 and 32 bits are intended widths. A second parameter picks how the carries into the groups are formed. The ripple-of-groups style passes the carry from one group to the next. The flat style gives each group carry its own sum-of-products over all lower groups and the carry-in. The per-group propagate and generate terms are also output, so that a surrounding datapath can reuse them and so that they can be observed directly.

Top module: `cla_adder`

## Requirements
- R1: `sum_o` equals the low WIDTH bits of `a_i + b_i + cin_i`, with the operands taken as unsigned.
- R2: `cout_o` equals bit WIDTH of that same (WIDTH+1)-bit total.
- R3: `grp_prop_o[k]` is 1 exactly when `a_i[4k+3:4k] + b_i[4k+3:4k]` equals 4'hF. Group 0 holds the least significant four bits.
- R4: `grp_gen_o[k]` is 1 exactly when `a_i[4k+3:4k] + b_i[4k+3:4k]` is 16 or more. It does not depend on `cin_i`.
- R5: When every group propagates, the carry-in passes straight through every group. With `cin_i`=1 the result is `sum_o`=0 and `cout_o`=1. With `cin_i`=0 the result is `sum_o` all ones and `cout_o`=0.
- R6: R1 to R5 hold for WIDTH=16, with four groups, and for WIDTH=32, with eight groups.
- R7: For the same inputs, `CHAIN`=`CHAIN_RIPPLE` and `CHAIN`=`CHAIN_FLAT` produce identical outputs.
- R8: No group has `grp_prop_o[k]` and `grp_gen_o[k]` high at the same time.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | WIDTH | First unsigned operand |
| b_i | input | WIDTH | Second unsigned operand |
| cin_i | input | 1 | Carry into bit 0 |
| sum_o | output | WIDTH | Sum, low WIDTH bits |
| cout_o | output | 1 | Carry out of the top group |
| grp_prop_o | output | WIDTH/4 | Group propagate, one bit per 4-bit group |
| grp_gen_o | output | WIDTH/4 | Group generate, one bit per 4-bit group |

## Verification
The hardest path to reach from the ports is the longest carry path. On that path group 0 generates and every group above it propagates, so a carry born in the lowest nibble must set `cout_o` with no help from any other group. Random operands almost never produce this pattern. The stimulus therefore builds it on purpose: one operand is all ones above the low nibble, and the two low nibbles overflow. Complementary alternating patterns make every group propagate for the carry-in pass-through. The same vectors drive both widths and both chain styles at once.

// File: rtl/cla_pkg.sv
package cla_pkg;
  localparam int GRP_W = 4;

  typedef enum logic {
    CHAIN_RIPPLE = 1'b0,
    CHAIN_FLAT   = 1'b1
  } chain_e;
endpackage

// File: rtl/cla_bit_pg.sv
module cla_bit_pg #(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  output logic [WIDTH-1:0] p_o,
  output logic [WIDTH-1:0] g_o
);
  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    assign p_o[i] = a_i[i] ^ b_i[i];
    assign g_o[i] = a_i[i] & b_i[i];
  end
endmodule

// File: rtl/cla_group_pg.sv
module cla_group_pg
  import cla_pkg::*;
(
  input  logic [GRP_W-1:0] p_i,
  input  logic [GRP_W-1:0] g_i,
  output logic             gp_o,
  output logic             gg_o
);
  assign gp_o = &p_i;
  assign gg_o = g_i[3]
              | (p_i[3] & g_i[2])
              | (p_i[3] & p_i[2] & g_i[1])
              | (p_i[3] & p_i[2] & p_i[1] & g_i[0]);
endmodule

// File: rtl/cla_group_sum.sv
module cla_group_sum
  import cla_pkg::*;
(
  input  logic [GRP_W-1:0] p_i,
  input  logic [GRP_W-1:0] g_i,
  input  logic             c_i,
  output logic [GRP_W-1:0] s_o
);
  logic [GRP_W-1:0] c;

  // two-level lookahead inside the group
  assign c[0] = c_i;
  assign c[1] = g_i[0] | (p_i[0] & c_i);
  assign c[2] = g_i[1] | (p_i[1] & g_i[0]) | (p_i[1] & p_i[0] & c_i);
  assign c[3] = g_i[2] | (p_i[2] & g_i[1]) | (p_i[2] & p_i[1] & g_i[0])
              | (p_i[2] & p_i[1] & p_i[0] & c_i);

  assign s_o = p_i ^ c;
endmodule

// File: rtl/cla_carry_net.sv
module cla_carry_net
  import cla_pkg::*;
#(
  parameter int     NUM_GRP = 8,
  parameter chain_e CHAIN   = CHAIN_FLAT
) (
  input  logic [NUM_GRP-1:0] gp_i,
  input  logic [NUM_GRP-1:0] gg_i,
  input  logic               cin_i,
  output logic [NUM_GRP:0]   gc_o
);
  if (CHAIN == CHAIN_RIPPLE) begin : g_ripple
    assign gc_o[0] = cin_i;
    for (genvar k = 0; k < NUM_GRP; k++) begin : g_stage
      assign gc_o[k+1] = gg_i[k] | (gp_i[k] & gc_o[k]);
    end
  end else begin : g_flat
    // each group carry is its own sum of products over all lower groups
    always_comb begin
      gc_o[0] = cin_i;
      for (int k = 1; k <= NUM_GRP; k++) begin
        logic term;
        logic run;
        term = 1'b0;
        for (int j = 0; j < k; j++) begin
          run = gg_i[j];
          for (int m = j + 1; m < k; m++) run = run & gp_i[m];
          term = term | run;
        end
        run = cin_i;
        for (int m = 0; m < k; m++) run = run & gp_i[m];
        gc_o[k] = term | run;
      end
    end
  end
endmodule

// File: rtl/cla_adder.sv
module cla_adder
  import cla_pkg::*;
#(
  parameter int     WIDTH = 32,
  parameter chain_e CHAIN = CHAIN_FLAT
) (
  input  logic [WIDTH-1:0]       a_i,
  input  logic [WIDTH-1:0]       b_i,
  input  logic                   cin_i,
  output logic [WIDTH-1:0]       sum_o,
  output logic                   cout_o,
  output logic [WIDTH/4-1:0]     grp_prop_o,
  output logic [WIDTH/4-1:0]     grp_gen_o
);
  localparam int NUM_GRP = WIDTH / GRP_W;

  logic [WIDTH-1:0]   bit_p;
  logic [WIDTH-1:0]   bit_g;
  logic [NUM_GRP-1:0] gp;
  logic [NUM_GRP-1:0] gg;
  logic [NUM_GRP:0]   gc;

  cla_bit_pg #(.WIDTH(WIDTH)) u_bit_pg (
    .a_i (a_i),
    .b_i (b_i),
    .p_o (bit_p),
    .g_o (bit_g)
  );

  for (genvar k = 0; k < NUM_GRP; k++) begin : g_grp
    cla_group_pg u_pg (
      .p_i  (bit_p[k*GRP_W +: GRP_W]),
      .g_i  (bit_g[k*GRP_W +: GRP_W]),
      .gp_o (gp[k]),
      .gg_o (gg[k])
    );

    cla_group_sum u_sum (
      .p_i (bit_p[k*GRP_W +: GRP_W]),
      .g_i (bit_g[k*GRP_W +: GRP_W]),
      .c_i (gc[k]),
      .s_o (sum_o[k*GRP_W +: GRP_W])
    );
  end

  cla_carry_net #(.NUM_GRP(NUM_GRP), .CHAIN(CHAIN)) u_carry (
    .gp_i  (gp),
    .gg_i  (gg),
    .cin_i (cin_i),
    .gc_o  (gc)
  );

  assign cout_o     = gc[NUM_GRP];
  assign grp_prop_o = gp;
  assign grp_gen_o  = gg;
endmodule

// File: rtl/cla_adder_chk.sv
module cla_adder_chk #(
  parameter int WIDTH = 32
) (
  input logic [WIDTH-1:0]   a_i,
  input logic [WIDTH-1:0]   b_i,
  input logic               cin_i,
  input logic [WIDTH-1:0]   sum_o,
  input logic               cout_o,
  input logic [WIDTH/4-1:0] grp_prop_o,
  input logic [WIDTH/4-1:0] grp_gen_o
);
  localparam int NUM_GRP = WIDTH / 4;

  always_comb begin
    p_sum_r1: assert ({cout_o, sum_o} ==
                      ({1'b0, a_i} + {1'b0, b_i} + {{WIDTH{1'b0}}, cin_i}));
    p_top_gen_r2: assert (!grp_gen_o[NUM_GRP-1] || cout_o);
    p_pass_r5: assert (!(&grp_prop_o) ||
                       ((cout_o == cin_i) && (sum_o == {WIDTH{~cin_i}})));
    for (int k = 0; k < NUM_GRP; k++) begin
      p_excl_r8: assert (!(grp_prop_o[k] && grp_gen_o[k]));
    end
  end
endmodule

bind cla_adder cla_adder_chk #(.WIDTH(WIDTH)) u_chk (
  .a_i        (a_i),
  .b_i        (b_i),
  .cin_i      (cin_i),
  .sum_o      (sum_o),
  .cout_o     (cout_o),
  .grp_prop_o (grp_prop_o),
  .grp_gen_o  (grp_gen_o)
);

// File: tb/cla_adder_test.sv
module cla_adder_test;
  import cla_pkg::*;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic [31:0] a, b;
  logic        cin;

  logic [31:0] s32f, s32r;
  logic        c32f, c32r;
  logic [7:0]  p32f, p32r, g32f, g32r;
  logic [15:0] s16f, s16r;
  logic        c16f, c16r;
  logic [3:0]  p16f, p16r, g16f, g16r;

  cla_adder #(.WIDTH(32), .CHAIN(CHAIN_FLAT)) uut (
    .a_i(a), .b_i(b), .cin_i(cin), .sum_o(s32f), .cout_o(c32f),
    .grp_prop_o(p32f), .grp_gen_o(g32f));
  cla_adder #(.WIDTH(32), .CHAIN(CHAIN_RIPPLE)) uut_r32 (
    .a_i(a), .b_i(b), .cin_i(cin), .sum_o(s32r), .cout_o(c32r),
    .grp_prop_o(p32r), .grp_gen_o(g32r));
  cla_adder #(.WIDTH(16), .CHAIN(CHAIN_FLAT)) uut_f16 (
    .a_i(a[15:0]), .b_i(b[15:0]), .cin_i(cin), .sum_o(s16f), .cout_o(c16f),
    .grp_prop_o(p16f), .grp_gen_o(g16f));
  cla_adder #(.WIDTH(16), .CHAIN(CHAIN_RIPPLE)) uut_r16 (
    .a_i(a[15:0]), .b_i(b[15:0]), .cin_i(cin), .sum_o(s16r), .cout_o(c16r),
    .grp_prop_o(p16r), .grp_gen_o(g16r));

  typedef struct {
    string       tag;
    logic [31:0] s32;
    logic        c32;
    logic [7:0]  p32, g32;
    logic [15:0] s16;
    logic        c16;
    logic [3:0]  p16, g16;
  } exp_t;

  exp_t exp_q[$];
  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  task automatic chk(input string req, input string what, input string inst,
                     input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s %s: actual=%h expected=%h", req, what, inst, act, exp);
    end
  endtask

  task automatic drive(input string tag, input logic [31:0] av,
                       input logic [31:0] bv, input logic cv);
    exp_t e;
    logic [32:0] t32;
    logic [16:0] t16;
    logic [4:0]  nib;
    @(negedge clk);
    a = av; b = bv; cin = cv;
    t32 = {1'b0, av} + {1'b0, bv} + {32'd0, cv};
    t16 = {1'b0, av[15:0]} + {1'b0, bv[15:0]} + {16'd0, cv};
    e.tag = tag;
    e.s32 = t32[31:0]; e.c32 = t32[32];
    e.s16 = t16[15:0]; e.c16 = t16[16];
    for (int k = 0; k < 8; k++) begin
      nib = {1'b0, av[4*k +: 4]} + {1'b0, bv[4*k +: 4]};
      e.p32[k] = (nib == 5'h0F);
      e.g32[k] = nib[4];
    end
    e.p16 = e.p32[3:0];
    e.g16 = e.g32[3:0];
    exp_q.push_back(e);
  endtask

  // monitor: results settle between negedge drive and posedge compare
  always @(posedge clk) begin
    if (exp_q.size() > 0) begin
      exp_t e;
      e = exp_q.pop_front();
      chk({e.tag, "/R1"}, "sum",  "f32", s32f, e.s32);
      chk({e.tag, "/R2"}, "cout", "f32", {31'd0, c32f}, {31'd0, e.c32});
      chk({e.tag, "/R3"}, "gp",   "f32", {24'd0, p32f}, {24'd0, e.p32});
      chk({e.tag, "/R4"}, "gg",   "f32", {24'd0, g32f}, {24'd0, e.g32});
      chk({e.tag, "/R8"}, "p&g",  "f32", {24'd0, p32f & g32f}, 32'd0);
      chk({e.tag, "/R7"}, "sum",  "r32", s32r, e.s32);
      chk({e.tag, "/R7"}, "cout", "r32", {31'd0, c32r}, {31'd0, e.c32});
      chk({e.tag, "/R7"}, "gpgg", "r32", {16'd0, p32r, g32r}, {16'd0, e.p32, e.g32});
      chk({e.tag, "/R6"}, "sum",  "f16", {16'd0, s16f}, {16'd0, e.s16});
      chk({e.tag, "/R6"}, "cout", "f16", {31'd0, c16f}, {31'd0, e.c16});
      chk({e.tag, "/R6"}, "gpgg", "f16", {24'd0, p16f, g16f}, {24'd0, e.p16, e.g16});
      chk({e.tag, "/R7"}, "sum",  "r16", {16'd0, s16r}, {16'd0, e.s16});
      chk({e.tag, "/R7"}, "cout", "r16", {31'd0, c16r}, {31'd0, e.c16});
      chk({e.tag, "/R7"}, "gpgg", "r16", {24'd0, p16r, g16r}, {24'd0, e.p16, e.g16});
    end
  end

  initial begin
    a = '0; b = '0; cin = 1'b0;
    drive("R1", 32'h0000_0000, 32'h0000_0000, 1'b0);   // idle zeros
    drive("R1", 32'h0000_0000, 32'h0000_0000, 1'b1);
    drive("R5", 32'hFFFF_FFFF, 32'h0000_0000, 1'b1);   // all ones + cin
    drive("R5", 32'hFFFF_FFFF, 32'h0000_0000, 1'b0);
    drive("R2", 32'hFFFF_FFFF, 32'h0000_0001, 1'b0);   // all ones + 1
    drive("R2", 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b1);
    drive("R5", 32'hAAAA_AAAA, 32'h5555_5555, 1'b0);   // every group propagates
    drive("R5", 32'hAAAA_AAAA, 32'h5555_5555, 1'b1);
    drive("R4", 32'hAAAA_AAAA, 32'hAAAA_AAAA, 1'b0);   // every group generates
    drive("R3", 32'h5555_5555, 32'h5555_5555, 1'b1);
    drive("R4", 32'hFFFF_FFF8, 32'h0000_0008, 1'b0);   // group 0 gen, rest propagate
    drive("R4", 32'h0000_FFF8, 32'hFFFF_0008, 1'b0);
    drive("R3", 32'h1234_5678, 32'hEDCB_A987, 1'b1);   // complementary
    drive("R3", 32'h0F0F_0F0F, 32'h0000_0000, 1'b0);
    for (int i = 0; i < 300; i++)
      drive("R1", $urandom, $urandom, 1'($urandom));
    for (int i = 0; i < 100; i++) begin
      logic [31:0] r;
      r = $urandom;
      drive("R5", r, ~r ^ (32'h1 << (i % 32)), 1'($urandom));
    end
    @(negedge clk);
    @(negedge clk);
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule